// File: doc/BRIEF.md
# BCD Up/Down Decade Counter

This block holds one decimal digit and steps it up or down by one on each rising clock edge while counting is enabled. A four-bit preset path loads any code. An asynchronous clear forces the digit to zero. An active-low terminal-count output flags the roll-over point, so several of these blocks can be chained into a multi-digit counter or a programmable divider.

The clear has the highest priority. The preset comes next, and counting comes last. The preset is level sensitive: while it is high, the output shows the preset value at once, without waiting for a clock. The six codes above nine can only be reached through the preset. The counter leaves them in a fixed way: in one count when stepping up, and in one or two counts when stepping down. The terminal-count output is combinational in the stored digit, the enable and the direction.

Top module: `bcd_updown_decade`

## Requirements
- R1: While `clr` is high, `q` is 0000 at once, with no clock edge needed, whatever `preset_en`, `cnt_en_n`, `count_up` and the clock are doing.
- R2: While `preset_en` is high and `clr` is low, `q` equals `preset_val` combinationally, including changes of `preset_val` between clock edges.
- R3: A rising edge with `preset_en` high stores `preset_val`. After `preset_en` falls, `q` keeps the value stored at the last such edge.
- R4: With `preset_en` low and `cnt_en_n` high, a rising edge leaves the stored digit unchanged, for either value of `count_up`.
- R5: With `preset_en` low, `cnt_en_n` low and `count_up` high (1 = up), a rising edge steps 0 through 8 up by one and steps 9 to 0.
- R6: Counting up from any code 10 to 15 gives 0 after one enabled edge.
- R7: With `count_up` low (down), an enabled edge steps 1 through 9 down by one and steps 0 to 9.
- R8: Counting down from an even code in 10 to 15 gives 9. Counting down from an odd code in 10 to 15 gives that code minus one. Any illegal code therefore reaches a BCD value within two counts.
- R9: With `count_up` high, `term_n` is low exactly when `cnt_en_n` is low and bits 0 and 3 of `q` are both high. This holds for 9, 11, 13 and 15. In all other up-count cases `term_n` is high.
- R10: With `count_up` low, `term_n` is low exactly when `cnt_en_n` is low and `q` is 0000. `term_n` follows changes of `cnt_en_n` and `count_up` without a clock edge.
- R11: A rising edge with both `preset_en` high and `cnt_en_n` low stores `preset_val`, not the next count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous clear, active high |
| preset_en | input | 1 | Level-sensitive preset, active high |
| preset_val | input | 4 | Preset code, bit 0 least significant |
| cnt_en_n | input | 1 | Count enable, active low |
| count_up | input | 1 | Direction: 1 counts up, 0 counts down |
| q | output | 4 | Current digit |
| term_n | output | 1 | Terminal count, active low |

## Verification
A preset and a count can fall on the same edge, and so can a clear and a preset. The bench provokes both cases. It holds `preset_en` high with `cnt_en_n` low at a rising edge, and it raises `clr` together with `preset_en` between edges. The reference model in the bench applies the clear, then the preset, then the count. Its digit is compared with `q` and `term_n` in every cycle, and a mid-cycle sample shows that the clear and the preset act without waiting for an edge. If the stored digit is the next count, or if `q` is non-zero while `clr` is high, the priority is wrong.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } count_dir_e;
endpackage

// File: rtl/bcd_step.sv
module bcd_step
   import bcd_cnt_pkg::*;
#(
   parameter int DW    = 4,
   parameter int RADIX = 10
) (
   input  logic [DW-1:0] cur,
   input  count_dir_e    dir,
   output logic [DW-1:0] nxt
);
   localparam logic [DW-1:0] LAST_V = (DW)'(RADIX - 1);

   always_comb begin
      if (dir == DIR_UP) begin
         // at or past the last digit: wrap, illegal codes included
         nxt = (cur >= LAST_V) ? '0 : cur + (DW)'(1);
      end else if (cur == '0) begin
         nxt = LAST_V;
      end else if (cur > LAST_V && !cur[0]) begin
         // even illegal code jumps straight to the top digit
         nxt = LAST_V;
      end else begin
         nxt = cur - (DW)'(1);
      end
   end
endmodule

// File: rtl/bcd_term_dec.sv
module bcd_term_dec
   import bcd_cnt_pkg::*;
#(
   parameter int DW    = 4,
   parameter int RADIX = 10
) (
   input  logic [DW-1:0] val,
   input  count_dir_e    dir,
   input  logic          en_n,
   output logic          term_n
);
   localparam logic [DW-1:0] LAST_V = (DW)'(RADIX - 1);

   logic at_top;

   generate
      if (RADIX == 10 && DW == 4) begin : g_sparse
         // two-bit decode of nine; it also flags 11, 13 and 15
         assign at_top = val[0] & val[DW-1];
      end else begin : g_full
         assign at_top = (val >= LAST_V);
      end
   endgenerate

   always_comb begin
      if (en_n) begin
         term_n = 1'b1;
      end else if (dir == DIR_UP) begin
         term_n = ~at_top;
      end else begin
         term_n = (val != '0);
      end
   end
endmodule

// File: rtl/bcd_cnt_reg.sv
module bcd_cnt_reg #(
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          ld,
   input  logic [DW-1:0] ld_val,
   input  logic          adv,
   input  logic [DW-1:0] adv_val,
   output logic [DW-1:0] st
);
   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         st <= '0;
      end else if (ld) begin
         st <= ld_val;
      end else if (adv) begin
         st <= adv_val;
      end
   end
endmodule

// File: rtl/bcd_updown_decade.sv
module bcd_updown_decade
   import bcd_cnt_pkg::*;
#(
   parameter int DW    = 4,
   parameter int RADIX = 10
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          preset_en,
   input  logic [DW-1:0] preset_val,
   input  logic          cnt_en_n,
   input  logic          count_up,
   output logic [DW-1:0] q,
   output logic          term_n
);
   localparam logic [DW-1:0] LAST_V = (DW)'(RADIX - 1);

   generate
      if (DW < 2) begin : g_bad_width
         $error("bcd_updown_decade: DW must be at least 2");
      end
      if (RADIX < 2 || RADIX > (1 << DW)) begin : g_bad_radix
         $error("bcd_updown_decade: RADIX must lie in 2 .. 2**DW");
      end
   endgenerate

   count_dir_e     dir;
   logic [DW-1:0]  st_q;
   logic [DW-1:0]  st_nxt;

   assign dir = count_up ? DIR_UP : DIR_DOWN;

   bcd_step #(.DW(DW), .RADIX(RADIX)) u_step (
      .cur (st_q),
      .dir (dir),
      .nxt (st_nxt)
   );

   bcd_cnt_reg #(.DW(DW)) u_reg (
      .clk     (clk),
      .clr     (clr),
      .ld      (preset_en),
      .ld_val  (preset_val),
      .adv     (~cnt_en_n),
      .adv_val (st_nxt),
      .st      (st_q)
   );

   // preset is transparent to the output until the next edge stores it
   always_comb begin
      if (clr) begin
         q = '0;
      end else if (preset_en) begin
         q = preset_val;
      end else begin
         q = st_q;
      end
   end

   bcd_term_dec #(.DW(DW), .RADIX(RADIX)) u_term (
      .val    (q),
      .dir    (dir),
      .en_n   (cnt_en_n),
      .term_n (term_n)
   );

   p_hold_r4: assert property (@(posedge clk) disable iff (clr)
      (!preset_en && cnt_en_n) |=> $stable(st_q));

   p_preset_store_r3: assert property (@(posedge clk) disable iff (clr)
      preset_en |=> (st_q == $past(preset_val)));

   p_preset_beats_count_r11: assert property (@(posedge clk) disable iff (clr)
      (preset_en && !cnt_en_n) |=> (st_q == $past(preset_val)));

   p_up_step_r5: assert property (@(posedge clk) disable iff (clr)
      (!preset_en && !cnt_en_n && count_up && st_q < LAST_V)
      |=> (st_q == $past(st_q) + (DW)'(1)));

   p_up_wrap_r6: assert property (@(posedge clk) disable iff (clr)
      (!preset_en && !cnt_en_n && count_up && st_q >= LAST_V)
      |=> (st_q == '0));

   p_down_step_r7: assert property (@(posedge clk) disable iff (clr)
      (!preset_en && !cnt_en_n && !count_up && st_q != '0 && st_q <= LAST_V)
      |=> (st_q == $past(st_q) - (DW)'(1)));

   p_down_wrap_r7: assert property (@(posedge clk) disable iff (clr)
      (!preset_en && !cnt_en_n && !count_up && st_q == '0)
      |=> (st_q == LAST_V));

   p_down_even_bad_r8: assert property (@(posedge clk) disable iff (clr)
      (!preset_en && !cnt_en_n && !count_up && st_q > LAST_V && !st_q[0])
      |=> (st_q == LAST_V));

   p_down_odd_bad_r8: assert property (@(posedge clk) disable iff (clr)
      (!preset_en && !cnt_en_n && !count_up && st_q > LAST_V && st_q[0])
      |=> (st_q == $past(st_q) - (DW)'(1)));
endmodule

// File: tb/sim_bcd_updown_decade.sv
module sim_bcd_updown_decade;
   logic       clk = 1'b0;
   logic       clr = 1'b1;
   logic       preset_en = 1'b0;
   logic [3:0] preset_val = 4'd0;
   logic       cnt_en_n = 1'b1;
   logic       count_up = 1'b1;
   logic [3:0] q;
   logic       term_n;

   int n_vec = 0;
   int n_bad = 0;
   int ref_st = 0;
   bit done = 0;

   always #4 clk = ~clk;

   bcd_updown_decade u0 (
      .clk        (clk),
      .clr        (clr),
      .preset_en  (preset_en),
      .preset_val (preset_val),
      .cnt_en_n   (cnt_en_n),
      .count_up   (count_up),
      .q          (q),
      .term_n     (term_n)
   );

   function automatic int next_of(input int v, input bit up);
      if (up) return (v >= 9) ? 0 : v + 1;
      if (v == 0) return 9;
      if (v > 9 && (v % 2) == 0) return 9;
      return v - 1;
   endfunction

   function automatic int shown();
      if (clr) return 0;
      if (preset_en) return int'(preset_val);
      return ref_st;
   endfunction

   task automatic compare(input string tag);
      int  qe;
      bit  tl;
      qe = shown();
      tl = !cnt_en_n && ((count_up && (qe % 2) == 1 && qe >= 8) ||
                         (!count_up && qe == 0));
      n_vec++;
      if (int'(q) !== qe) begin
         n_bad++;
         $display("FAIL %s q got %0d expected %0d", tag, q, qe);
      end
      n_vec++;
      if (term_n !== !tl) begin
         n_bad++;
         $display("FAIL %s term_n got %0b expected %0b", tag, term_n, !tl);
      end
   endtask

   // drive after the falling edge, compare mid-cycle, advance model at rise
   task automatic step(input bit c, input bit p, input int d, input bit en_n,
                       input bit up, input string tag);
      @(negedge clk);
      clr = c; preset_en = p; preset_val = 4'(d); cnt_en_n = en_n; count_up = up;
      if (c) ref_st = 0;
      #1;
      compare(tag);
      @(posedge clk);
      if (clr) ref_st = 0;
      else if (preset_en) ref_st = int'(preset_val);
      else if (!cnt_en_n) ref_st = next_of(ref_st, count_up);
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      // R1: clear holds zero even with preset and count requested
      step(1, 1, 6, 0, 1, "R1");
      step(1, 0, 0, 0, 0, "R1");
      // R2: preset transparent, changes between edges
      step(0, 1, 3, 1, 1, "R2");
      @(negedge clk); preset_val = 4'd5; #1; compare("R2");
      preset_val = 4'd7; #1; compare("R2");
      @(posedge clk); ref_st = 7;
      // R3: value kept after preset falls
      step(0, 0, 0, 1, 0, "R3");
      // R5: up count with wrap
      for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, "R5");
      // R4: hold, direction toggling
      step(0, 0, 0, 1, 0, "R4");
      step(0, 0, 0, 1, 1, "R4");
      step(0, 0, 0, 1, 0, "R4");
      // R7: down through zero
      for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, "R7");
      // R11: preset wins over count on the same edge
      step(0, 1, 4, 0, 1, "R11");
      step(0, 0, 0, 1, 1, "R11");
      // R6: each illegal code, one up count
      for (int v = 10; v < 16; v++) begin
         step(0, 1, v, 1, 1, "R6");
         step(0, 0, 0, 0, 1, "R6");
         step(0, 0, 0, 1, 1, "R6");
      end
      // R8: each illegal code, two down counts
      for (int v = 10; v < 16; v++) begin
         step(0, 1, v, 1, 0, "R8");
         step(0, 0, 0, 0, 0, "R8");
         step(0, 0, 0, 0, 0, "R8");
         step(0, 0, 0, 1, 0, "R8");
      end
      // R9: terminal count on 9 and 11, enable and direction toggled
      step(0, 1, 9, 1, 1, "R9");
      step(0, 0, 0, 1, 1, "R9");
      @(negedge clk); cnt_en_n = 0; #1; compare("R9");
      count_up = 0; #1; compare("R10");
      cnt_en_n = 1; #1; compare("R9");
      step(0, 1, 11, 1, 1, "R9");
      step(0, 0, 0, 1, 1, "R9");
      @(negedge clk); cnt_en_n = 0; #1; compare("R9");
      cnt_en_n = 1; #1; compare("R9");
      // R10: zero while counting down, then up
      step(0, 1, 0, 1, 0, "R10");
      step(0, 0, 0, 1, 0, "R10");
      @(negedge clk); cnt_en_n = 0; #1; compare("R10");
      count_up = 1; #1; compare("R10");
      cnt_en_n = 1; #1; compare("R10");
      // R1: clear between edges while counting and presetting
      step(0, 1, 8, 1, 1, "R1");
      step(0, 0, 0, 0, 1, "R1");
      @(negedge clk); clr = 1; preset_en = 1; preset_val = 4'd6; ref_st = 0;
      #1; compare("R1");
      @(posedge clk);
      step(0, 0, 0, 0, 1, "R1");
      step(0, 0, 0, 1, 1, "R1");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule